// File: doc/BRIEF.md
# Aligned Contiguous Slot Allocator

This block manages a table of `NUM_SLOTS` entries. Each entry is either free or taken, and a taken entry carries a one-bit kind tag. A requester asks for a run of consecutive free entries. The request gives a length, an alignment flag and a kind. The block answers with the external number of the first entry of the run, which is the table position plus `BASE`, or with a failure. On success it marks the whole run as taken.

A single entry can also be claimed at a chosen number, which succeeds only when that entry is free. A run can be released: each entry in it is cleared, and a warning is raised if any of them was already free. Run searches walk the table one candidate start per clock. They begin at position 0. The step is the run length when alignment is requested and one otherwise. The search stops with a failure as soon as the rest of the table is too short to hold the run.

Claims, releases and rejected requests finish in one clock. The table contents are visible on two flat bit maps, so the block above can see which entries are taken and how each one is tagged.

Top module: `slot_run_alloc`

## Requirements
- R1: A search starts at position 0 and advances by the run length when `req_align`=1, or by 1 otherwise. It examines one candidate start per clock. When a search examines k candidates, `done` is high in the cycle that begins k rising edges after the edge that accepted the request.
- R2: A request is rejected with `err`, the table is left unchanged, and `done` follows on the next edge, in any of these cases: `req_op`=3; an allocate whose length is 0 or greater than `NUM_SLOTS`; an aligned allocate whose length is not a power of two no larger than `MAX_ALIGN` (1, 2, 4, 8, 16 or 32 by default).
- R3: A search reports `fail` at the first candidate start s for which s + length > `NUM_SLOTS`, without looking at any later start.
- R4: A search picks the lowest candidate start whose entire run is free (first fit).
- R5: On a successful allocate (`req_op`=0), every entry of the run becomes taken. Its bit in `kind_map` is set to `req_kind` (0 = level kind, 1 = pulse kind). `result` equals `BASE` plus the start position. Bit i of `used_map` and of `kind_map` describes entry i.
- R6: A claim (`req_op`=1) targets entry `req_index` − `BASE`. If that entry is inside the table and free, the claim marks it taken with `req_kind`, sets `ok`, and returns `result` = `req_index`. Otherwise it reports `fail` and leaves the table unchanged. It completes on the accepting edge.
- R7: A release (`req_op`=2) of `req_count` entries from `req_index` − `BASE` clears both the taken bit and the kind bit of each entry and reports `ok`. `warn` is set as well if any entry in the run was already free. A release that starts outside the table, runs past its end, or has length 0 reports `err` and changes nothing.
- R8: `busy` is high for the whole of a search, and a request presented while `busy` is high is ignored. Each completion gives `done` for a single cycle, with exactly one of `ok`, `fail` and `err`.
- R9: After reset the table is empty, and `busy`, `done`, `ok`, `fail`, `err` and `warn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when the block is idle |
| req_op | input | 2 | 0 allocate, 1 claim, 2 release, 3 reserved |
| req_count | input | $clog2(NUM_SLOTS)+1 | Run length |
| req_align | input | 1 | Align the run start to its length |
| req_kind | input | 1 | Kind tag for allocate and claim |
| req_index | input | IDX_W | External number for claim or release start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Request succeeded |
| fail | output | 1 | No room, or claimed entry not available |
| err | output | 1 | Illegal request |
| warn | output | 1 | Release touched an entry that was already free |
| result | output | IDX_W | External number of the allocated run start |
| used_map | output | NUM_SLOTS | Taken bit per entry |
| kind_map | output | NUM_SLOTS | Kind bit per entry |

## Verification
A table bit stuck or cleared wrongly shows on `used_map` the cycle after the request completes. It also changes which start a later first-fit search returns. A wrong step or a late stop in the search does not always change the result, but it does change the `done` latency. For that reason every search is checked for its exact cycle count as well as its result. A missing or wrong warning on release, or a claim that overwrites a taken entry, shows directly on `warn`, `fail` or the maps in the same completion cycle.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

  typedef enum logic [1:0] {
    OP_ALLOC   = 2'd0,
    OP_CLAIM   = 2'd1,
    OP_RELEASE = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  typedef enum logic {
    KIND_LEVEL = 1'b0,
    KIND_PULSE = 1'b1
  } kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } state_e;

endpackage

// File: rtl/run_mask.sv
module run_mask #(
  parameter int NUM_SLOTS = 64,
  localparam int W = $clog2(NUM_SLOTS) + 1
) (
  input  logic [W-1:0]         start,
  input  logic [W-1:0]         count,
  output logic [NUM_SLOTS-1:0] mask
);

  logic [W:0] start_ext;
  logic [W:0] end_ext;

  assign start_ext = {1'b0, start};
  assign end_ext   = {1'b0, start} + {1'b0, count};

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bit
    localparam logic [W:0] POS = (W+1)'(g);
    assign mask[g] = (start_ext <= POS) && (POS < end_ext);
  end

endmodule

// File: rtl/align_rule.sv
module align_rule #(
  parameter int NUM_SLOTS = 64,
  parameter int MAX_ALIGN = 32,
  localparam int W = $clog2(NUM_SLOTS) + 1
) (
  input  logic [W-1:0] count,
  input  logic         align,
  output logic         legal,
  output logic [W-1:0] step
);

  logic pow2;
  logic in_table;

  assign pow2     = (count != '0) && ((count & (count - W'(1))) == '0);
  assign in_table = (count != '0) && (count <= W'(NUM_SLOTS));
  assign legal    = in_table && (!align || (pow2 && (count <= W'(MAX_ALIGN))));
  assign step     = align ? count : W'(1);

endmodule

// File: rtl/slot_table.sv
module slot_table #(
  parameter int NUM_SLOTS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic                 clr_en,
  input  logic                 set_kind,
  input  logic [NUM_SLOTS-1:0] mask,
  output logic [NUM_SLOTS-1:0] used_q,
  output logic [NUM_SLOTS-1:0] kind_q
);

  logic [NUM_SLOTS-1:0] used_d;
  logic [NUM_SLOTS-1:0] kind_d;
  logic                 tbl_en;

  assign tbl_en = set_en || clr_en;

  always_comb begin
    used_d = used_q;
    kind_d = kind_q;
    if (set_en) begin
      used_d = used_q | mask;
      kind_d = set_kind ? (kind_q | mask) : (kind_q & ~mask);
    end else if (clr_en) begin
      used_d = used_q & ~mask;
      kind_d = kind_q & ~mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      kind_q <= '0;
    end else if (tbl_en) begin
      used_q <= used_d;
      kind_q <= kind_d;
    end
  end

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en)); // R8

  AST_SET_MARKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((used_q & $past(mask)) == $past(mask))); // R5

  AST_CLR_EMPTIES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((used_q & $past(mask)) == '0) && ((kind_q & $past(mask)) == '0)); // R7

endmodule

// File: rtl/alloc_ctrl.sv
module alloc_ctrl
  import slot_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int IDX_W     = 16,
  parameter int BASE      = 4096,
  localparam int W = $clog2(NUM_SLOTS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [W-1:0]         req_count,
  input  logic                 req_kind,
  input  logic                 req_align,
  input  logic [IDX_W-1:0]     req_index,
  input  logic                 rule_legal,
  input  logic [W-1:0]         rule_step,
  input  logic [NUM_SLOTS-1:0] used_q,
  input  logic [NUM_SLOTS-1:0] mask,
  output logic [W-1:0]         m_start,
  output logic [W-1:0]         m_count,
  output logic                 set_en,
  output logic                 clr_en,
  output logic                 set_kind,
  output logic                 busy,
  output logic                 done,
  output logic                 ok,
  output logic                 fail,
  output logic                 err,
  output logic                 warn,
  output logic [IDX_W-1:0]     result
);

  state_e           state_q, state_d;
  logic [W-1:0]     start_q, start_d;
  logic [W-1:0]     cnt_q, cnt_d;
  logic [W-1:0]     step_q, step_d;
  logic             kind_q, kind_d;
  logic             align_q, align_d;
  op_e              op_q, op_d;
  logic             done_d, ok_d, fail_d, err_d, warn_d;
  logic [IDX_W-1:0] result_d;

  logic             below_base;
  logic [IDX_W-1:0] rel_full;
  logic             in_range;
  logic             run_fits;
  logic             run_clear;
  logic             run_over;

  assign below_base = req_index < IDX_W'(BASE);
  assign rel_full   = req_index - IDX_W'(BASE);
  assign in_range   = !below_base && (rel_full < IDX_W'(NUM_SLOTS));
  assign run_fits   = ({1'b0, rel_full} + (IDX_W+1)'(req_count)) <= (IDX_W+1)'(NUM_SLOTS);
  assign run_clear  = (used_q & mask) == '0;
  assign run_over   = ({1'b0, start_q} + {1'b0, cnt_q}) > (W+1)'(NUM_SLOTS);
  assign busy       = (state_q == ST_SCAN);

  always_comb begin
    state_d  = state_q;
    start_d  = start_q;
    cnt_d    = cnt_q;
    step_d   = step_q;
    kind_d   = kind_q;
    align_d  = align_q;
    op_d     = op_q;
    done_d   = 1'b0;
    ok_d     = 1'b0;
    fail_d   = 1'b0;
    err_d    = 1'b0;
    warn_d   = 1'b0;
    result_d = result;
    set_en   = 1'b0;
    clr_en   = 1'b0;
    set_kind = kind_q;
    m_start  = start_q;
    m_count  = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_d = op_e'(req_op);
          unique case (op_e'(req_op))
            OP_ALLOC: begin
              if (rule_legal) begin
                state_d = ST_SCAN;
                start_d = '0;
                cnt_d   = req_count;
                step_d  = rule_step;
                kind_d  = req_kind;
                align_d = req_align;
              end else begin
                done_d = 1'b1;
                err_d  = 1'b1;
              end
            end
            OP_CLAIM: begin
              m_start = rel_full[W-1:0];
              m_count = W'(1);
              done_d  = 1'b1;
              if (in_range && run_clear) begin
                set_en   = 1'b1;
                set_kind = req_kind;
                ok_d     = 1'b1;
                result_d = req_index;
              end else begin
                fail_d = 1'b1;
              end
            end
            OP_RELEASE: begin
              m_start = rel_full[W-1:0];
              m_count = req_count;
              done_d  = 1'b1;
              if (in_range && run_fits && (req_count != '0)) begin
                clr_en = 1'b1;
                ok_d   = 1'b1;
                warn_d = ((~used_q & mask) != '0);
              end else begin
                err_d = 1'b1;
              end
            end
            default: begin
              done_d = 1'b1;
              err_d  = 1'b1;
            end
          endcase
        end
      end
      ST_SCAN: begin
        if (run_over) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          fail_d  = 1'b1;
        end else if (run_clear) begin
          state_d  = ST_IDLE;
          set_en   = 1'b1;
          done_d   = 1'b1;
          ok_d     = 1'b1;
          result_d = IDX_W'(BASE) + IDX_W'(start_q);
        end else begin
          start_d = start_q + step_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= '0;
      cnt_q   <= '0;
      step_q  <= '0;
      kind_q  <= 1'b0;
      align_q <= 1'b0;
      op_q    <= OP_ALLOC;
      done    <= 1'b0;
      ok      <= 1'b0;
      fail    <= 1'b0;
      err     <= 1'b0;
      warn    <= 1'b0;
      result  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      step_q  <= step_d;
      kind_q  <= kind_d;
      align_q <= align_d;
      op_q    <= op_d;
      done    <= done_d;
      ok      <= ok_d;
      fail    <= fail_d;
      err     <= err_d;
      warn    <= warn_d;
      result  <= result_d;
    end
  end

  AST_DONE_OUTSIDE_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({ok, fail, err}) == 1)); // R8

  AST_OUTCOME_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ok || fail || err || warn) |-> done); // R8

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (start_q == $past(start_q) + $past(step_q))); // R1

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (start_q <= W'(NUM_SLOTS))); // R3

  AST_ALIGNED_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && (op_q == OP_ALLOC) && align_q) |->
      (((result[W-1:0] - W'(BASE)) & (cnt_q - W'(1))) == '0)); // R1

endmodule

// File: rtl/slot_run_alloc.sv
module slot_run_alloc #(
  parameter int NUM_SLOTS = 64,
  parameter int MAX_ALIGN = 32,
  parameter int IDX_W     = 16,
  parameter int BASE      = 4096,
  localparam int W = $clog2(NUM_SLOTS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [W-1:0]         req_count,
  input  logic                 req_align,
  input  logic                 req_kind,
  input  logic [IDX_W-1:0]     req_index,
  output logic                 busy,
  output logic                 done,
  output logic                 ok,
  output logic                 fail,
  output logic                 err,
  output logic                 warn,
  output logic [IDX_W-1:0]     result,
  output logic [NUM_SLOTS-1:0] used_map,
  output logic [NUM_SLOTS-1:0] kind_map
);

  logic [1:0]           rst_pipe;
  logic                 rst_int_n;
  logic                 rule_legal;
  logic [W-1:0]         rule_step;
  logic [W-1:0]         m_start;
  logic [W-1:0]         m_count;
  logic [NUM_SLOTS-1:0] mask;
  logic                 set_en;
  logic                 clr_en;
  logic                 set_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  align_rule #(.NUM_SLOTS(NUM_SLOTS), .MAX_ALIGN(MAX_ALIGN)) u_rule (
    .count (req_count),
    .align (req_align),
    .legal (rule_legal),
    .step  (rule_step)
  );

  run_mask #(.NUM_SLOTS(NUM_SLOTS)) u_mask (
    .start (m_start),
    .count (m_count),
    .mask  (mask)
  );

  slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_en   (set_en),
    .clr_en   (clr_en),
    .set_kind (set_kind),
    .mask     (mask),
    .used_q   (used_map),
    .kind_q   (kind_map)
  );

  alloc_ctrl #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .BASE(BASE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_count  (req_count),
    .req_kind   (req_kind),
    .req_align  (req_align),
    .req_index  (req_index),
    .rule_legal (rule_legal),
    .rule_step  (rule_step),
    .used_q     (used_map),
    .mask       (mask),
    .m_start    (m_start),
    .m_count    (m_count),
    .set_en     (set_en),
    .clr_en     (clr_en),
    .set_kind   (set_kind),
    .busy       (busy),
    .done       (done),
    .ok         (ok),
    .fail       (fail),
    .err        (err),
    .warn       (warn),
    .result     (result)
  );

  AST_ERR_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    err |-> ((used_map == $past(used_map)) && (kind_map == $past(kind_map)))); // R2

  AST_FAIL_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    fail |-> (used_map == $past(used_map))); // R6

  AST_KIND_ONLY_ON_USED: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((kind_map & ~used_map) == '0)); // R5

endmodule

// File: tb/slot_run_alloc_bench.sv
module slot_run_alloc_bench;

  localparam int N    = 64;
  localparam int BASE = 4096;
  localparam int W    = $clog2(N) + 1;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [W-1:0] req_count;
  logic        req_align;
  logic        req_kind;
  logic [15:0] req_index;
  logic        busy, done, ok, fail, err, warn;
  logic [15:0] result;
  logic [N-1:0] used_map, kind_map;

  int n_checks;
  int n_errors;
  int r_lat;
  logic r_ok, r_fail, r_err, r_warn, r_busy1;
  logic [15:0] r_result;
  logic [N-1:0] exp_used, exp_kind;

  slot_run_alloc u_slot_run_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_count(req_count), .req_align(req_align), .req_kind(req_kind),
    .req_index(req_index), .busy(busy), .done(done), .ok(ok), .fail(fail),
    .err(err), .warn(warn), .result(result), .used_map(used_map),
    .kind_map(kind_map)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] run_bits(input int s, input int c);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) if (i >= s && i < s + c) m[i] = 1'b1;
    return m;
  endfunction

  // Drive one request and wait for done; optionally poke a release while busy.
  task automatic issue(input logic [1:0] op, input int cnt, input bit aln,
                       input bit knd, input int idx, input bit poke);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_count = W'(cnt);
    req_align = aln; req_kind = knd; req_index = 16'(idx);
    r_lat = 0;
    r_busy1 = 1'b0;
    do begin
      @(negedge clk);
      r_lat++;
      req_valid = 1'b0;
      if (r_lat == 1) r_busy1 = busy;
      if (poke && r_lat == 1) begin
        req_valid = 1'b1; req_op = 2'd2; req_count = W'(1); req_index = 16'(BASE);
      end
    end while (!done && r_lat < 300);
    req_valid = 1'b0;
    r_ok = ok; r_fail = fail; r_err = err; r_warn = warn; r_result = result;
  endtask

  task automatic outcome(input string tag, input bit eo, input bit ef, input bit ee, input int lat);
    chk({tag, " outcome"}, {r_ok, r_fail, r_err}, {eo, ef, ee});
    chk({tag, " latency"}, r_lat, lat);
  endtask

  task automatic maps(input string tag);
    chk({tag, " used_map"}, used_map, exp_used);
    chk({tag, " kind_map"}, kind_map, exp_kind);
  endtask

  task automatic t_reset;
    chk("R9 used_map", used_map, 0);
    chk("R9 kind_map", kind_map, 0);
    chk("R9 flags", {busy, done, ok, fail, err, warn}, 0);
  endtask

  task automatic t_basic_alloc;
    issue(2'd0, 1, 0, 0, 0, 0);
    outcome("R1 single", 1, 0, 0, 2);
    chk("R5 result single", r_result, BASE);
    exp_used |= run_bits(0, 1);
    maps("R5 single");
    issue(2'd0, 4, 1, 1, 0, 0);
    outcome("R1 aligned4", 1, 0, 0, 3);
    chk("R1 result aligned4", r_result, BASE + 4);
    exp_used |= run_bits(4, 4); exp_kind |= run_bits(4, 4);
    maps("R5 aligned4");
    issue(2'd0, 3, 0, 0, 0, 0);
    outcome("R4 firstfit3", 1, 0, 0, 3);
    chk("R4 result firstfit3", r_result, BASE + 1);
    exp_used |= run_bits(1, 3);
    maps("R4 firstfit3");
  endtask

  task automatic t_illegal;
    issue(2'd0, 3, 1, 0, 0, 0);
    outcome("R2 align3", 0, 0, 1, 1);
    issue(2'd0, 64, 1, 0, 0, 0);
    outcome("R2 align64", 0, 0, 1, 1);
    issue(2'd0, 0, 0, 0, 0, 0);
    outcome("R2 count0", 0, 0, 1, 1);
    issue(2'd3, 1, 0, 0, 0, 0);
    outcome("R2 reserved op", 0, 0, 1, 1);
    maps("R2 unchanged");
  endtask

  task automatic t_claim;
    issue(2'd1, 1, 0, 1, BASE + 10, 0);
    outcome("R6 claim free", 1, 0, 0, 1);
    chk("R6 claim result", r_result, BASE + 10);
    exp_used[10] = 1'b1; exp_kind[10] = 1'b1;
    maps("R6 claim");
    issue(2'd1, 1, 0, 0, BASE + 10, 0);
    outcome("R6 claim taken", 0, 1, 0, 1);
    issue(2'd1, 1, 0, 0, BASE + 64, 0);
    outcome("R6 claim above", 0, 1, 0, 1);
    issue(2'd1, 1, 0, 0, BASE - 1, 0);
    outcome("R6 claim below", 0, 1, 0, 1);
    maps("R6 unchanged");
  endtask

  task automatic t_release;
    issue(2'd2, 4, 0, 0, BASE + 4, 0);
    outcome("R7 release", 1, 0, 0, 1);
    chk("R7 no warn", r_warn, 0);
    exp_used &= ~run_bits(4, 4); exp_kind &= ~run_bits(4, 4);
    maps("R7 release");
    issue(2'd2, 2, 0, 0, BASE + 4, 0);
    outcome("R7 double release", 1, 0, 0, 1);
    chk("R7 warn", r_warn, 1);
    issue(2'd2, 2, 0, 0, BASE - 2, 0);
    outcome("R7 below", 0, 0, 1, 1);
    issue(2'd2, 4, 0, 0, BASE + 62, 0);
    outcome("R7 past end", 0, 0, 1, 1);
    maps("R7 unchanged");
  endtask

  task automatic t_scan;
    issue(2'd0, 60, 0, 0, 0, 0);
    outcome("R3 early stop", 0, 1, 0, 7);
    chk("R8 busy in scan", r_busy1, 1);
    issue(2'd0, 32, 1, 1, 0, 0);
    outcome("R1 aligned32", 1, 0, 0, 3);
    chk("R1 result aligned32", r_result, BASE + 32);
    exp_used |= run_bits(32, 32); exp_kind |= run_bits(32, 32);
    maps("R5 aligned32");
    issue(2'd0, 32, 1, 1, 0, 0);
    outcome("R3 aligned32 full", 0, 1, 0, 4);
    issue(2'd0, 1, 0, 0, 0, 0);
    outcome("R4 single scan", 1, 0, 0, 6);
    chk("R4 result single scan", r_result, BASE + 4);
    exp_used[4] = 1'b1;
    maps("R4 single scan");
  endtask

  task automatic t_busy_ignore;
    issue(2'd0, 20, 0, 0, 0, 1);
    outcome("R8 long scan", 1, 0, 0, 13);
    chk("R4 result long scan", r_result, BASE + 11);
    exp_used |= run_bits(11, 20);
    maps("R8 request while busy ignored");
  endtask

  initial begin
    n_checks = 0; n_errors = 0;
    exp_used = '0; exp_kind = '0;
    req_valid = 1'b0; req_op = 2'd0; req_count = '0;
    req_align = 1'b0; req_kind = 1'b0; req_index = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic_alloc();
    t_illegal();
    t_claim();
    t_release();
    t_scan();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule